// File: doc/BRIEF.md
# Block Compressed Texel Decoder

This block turns one 64-bit compressed texture block, which describes a 4x4 tile of texels at a fixed cost of 4 bits per texel, into a single 32-bit RGBA texel. The caller presents the block and a 4-bit texel number with a valid strobe. One clock later the decoded texel appears with its own valid strobe. Blocks and texel numbers may change on every cycle, so back-to-back lookups run at full rate.

Each block carries two 16-bit endpoint colours and sixteen 2-bit palette selectors. The decoder widens both endpoints to 8 bits per channel. It builds a four-entry palette from them and picks the entry named by the selected texel's selector. The palette has two forms. If the first endpoint is greater than the second, read as an unsigned integer, two interpolated colours lie at the thirds between them. Otherwise the third entry is the midpoint and the fourth is fully transparent black.

Top module: `texel_block_decoder`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and texel_o is 32'h0.
- R2: out_valid_o in a cycle equals in_valid_i in the cycle before.
- R3: Endpoint E0 is block_i[15:0] and endpoint E1 is block_i[31:16]. The 2-bit selector of texel n (0..15) is block_i[33+2n:32+2n].
- R4: An endpoint packs red in [15:11], green in [10:5] and blue in [4:0]. Each channel is widened to 8 bits by repeating its top bits below it (5-bit v gives {v, v[4:2]}, 6-bit v gives {v, v[5:4]}).
- R5: Selector 0 gives widened E0 and selector 1 gives widened E1, both with alpha 255.
- R6: If E0 > E1 as unsigned 16-bit values, selector 2 gives (2*a0+a1)/3 and selector 3 gives (a0+2*a1)/3 per colour channel, truncated, with alpha 255.
- R7: If E0 <= E1, including E0 == E1, selector 2 gives (a0+a1)/2 per colour channel, truncated, with alpha 255.
- R8: If E0 <= E1, selector 3 gives 32'h0000_0000.
- R9: texel_o packs red in [31:24], green in [23:16], blue in [15:8] and alpha in [7:0].
- R10: In a cycle after in_valid_i was low, texel_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Block and texel number are valid |
| block_i | input | 64 | Compressed 4x4 block |
| texel_idx_i | input | 4 | Texel number inside the block, row-major |
| out_valid_o | output | 1 | texel_o holds a new result |
| texel_o | output | 32 | Decoded RGBA8 texel |

## Verification
Choosing the palette form and extracting the selector happen in the same cycle. A single texel therefore depends on both the endpoint comparison and its position in the block. The bench provokes this with random blocks, some built with equal endpoints and some with swapped endpoints, while it sweeps texel numbers back to back. A behavioural reference model predicts each texel from integer arithmetic. The bench checks every output cycle against that model, with each result tagged by the palette form and the selector value involved.

// File: rtl/tex_dec_pkg.sv
package tex_dec_pkg;
  localparam int CH_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] a;
  } rgba8_t;

  localparam logic [CH_W-1:0] ALPHA_OPAQUE = '1;
endpackage

// File: rtl/chan_widen.sv
module chan_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  // fill from MSB down, repeating the source bits
  always_comb begin
    for (int k = 0; k < OUT_W; k++) begin
      val_o[OUT_W-1-k] = val_i[IN_W-1-(k % IN_W)];
    end
  end
endmodule

// File: rtl/color_expand.sv
module color_expand
  import tex_dec_pkg::*;
#(
  parameter int R_W = 5,
  parameter int G_W = 6,
  parameter int B_W = 5,
  localparam int COL_W = R_W + G_W + B_W
) (
  input  logic [COL_W-1:0] col_i,
  output rgba8_t           col_o
);
  logic [CH_W-1:0] r_w, g_w, b_w;

  chan_widen #(.IN_W(R_W), .OUT_W(CH_W)) u_r (
    .val_i(col_i[COL_W-1 -: R_W]), .val_o(r_w));
  chan_widen #(.IN_W(G_W), .OUT_W(CH_W)) u_g (
    .val_i(col_i[B_W +: G_W]), .val_o(g_w));
  chan_widen #(.IN_W(B_W), .OUT_W(CH_W)) u_b (
    .val_i(col_i[B_W-1:0]), .val_o(b_w));

  always_comb begin
    col_o.r = r_w;
    col_o.g = g_w;
    col_o.b = b_w;
    col_o.a = ALPHA_OPAQUE;
  end
endmodule

// File: rtl/chan_blend.sv
module chan_blend #(
  parameter int W = 8,
  localparam int SW = W + 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] near_a_o,
  output logic [W-1:0] near_b_o,
  output logic [W-1:0] mid_o
);
  logic [SW-1:0] ea, eb, s_a, s_b, s_m, q_a, q_b;

  always_comb begin
    ea  = SW'(a_i);
    eb  = SW'(b_i);
    s_a = (ea << 1) + eb;
    s_b = ea + (eb << 1);
    s_m = ea + eb;
    q_a = s_a / SW'(3);
    q_b = s_b / SW'(3);
    near_a_o = q_a[W-1:0];
    near_b_o = q_b[W-1:0];
    mid_o    = s_m[W:1];
  end
endmodule

// File: rtl/palette_gen.sv
module palette_gen
  import tex_dec_pkg::*;
#(
  parameter int COL_W = 16,
  parameter int N_PAL = 4
) (
  input  logic [COL_W-1:0]       c0_i,
  input  logic [COL_W-1:0]       c1_i,
  input  rgba8_t                 e0_i,
  input  rgba8_t                 e1_i,
  output rgba8_t [N_PAL-1:0]     pal_o
);
  localparam int N_CH = 3;

  logic four_col;
  logic [N_CH-1:0][CH_W-1:0] ch0, ch1, na, nb, md;

  assign four_col = c0_i > c1_i;
  assign ch0 = {e0_i.r, e0_i.g, e0_i.b};
  assign ch1 = {e1_i.r, e1_i.g, e1_i.b};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    chan_blend #(.W(CH_W)) u_blend (
      .a_i     (ch0[c]),
      .b_i     (ch1[c]),
      .near_a_o(na[c]),
      .near_b_o(nb[c]),
      .mid_o   (md[c])
    );
  end

  always_comb begin
    pal_o[0] = e0_i;
    pal_o[1] = e1_i;
    if (four_col) begin
      pal_o[2] = {na[2], na[1], na[0], ALPHA_OPAQUE};
      pal_o[3] = {nb[2], nb[1], nb[0], ALPHA_OPAQUE};
    end else begin
      pal_o[2] = {md[2], md[1], md[0], ALPHA_OPAQUE};
      pal_o[3] = '0;  // transparent black
    end
  end
endmodule

// File: rtl/texel_block_decoder.sv
module texel_block_decoder
  import tex_dec_pkg::*;
#(
  parameter int BLOCK_W = 64,
  parameter int COL_W   = 16,
  parameter int SEL_W   = 2,
  parameter int N_TEX   = 16,
  localparam int TIDX_W = $clog2(N_TEX),
  localparam int N_PAL  = 1 << SEL_W,
  localparam int PIX_W  = 4 * CH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [BLOCK_W-1:0]  block_i,
  input  logic [TIDX_W-1:0]   texel_idx_i,
  output logic                out_valid_o,
  output logic [PIX_W-1:0]    texel_o
);
  localparam int SELS_W = SEL_W * N_TEX;

  logic [COL_W-1:0]  c0, c1;
  logic [SELS_W-1:0] sels;
  logic [SEL_W-1:0]  sel;
  rgba8_t            e0, e1, pick;
  rgba8_t [N_PAL-1:0] pal;

  assign c0   = block_i[COL_W-1:0];
  assign c1   = block_i[2*COL_W-1:COL_W];
  assign sels = block_i[2*COL_W +: SELS_W];

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_TEX; i++) begin
      if (texel_idx_i == TIDX_W'(i)) sel = sels[i*SEL_W +: SEL_W];
    end
  end

  color_expand u_exp0 (.col_i(c0), .col_o(e0));
  color_expand u_exp1 (.col_i(c1), .col_o(e1));

  palette_gen #(.COL_W(COL_W), .N_PAL(N_PAL)) u_pal (
    .c0_i (c0),
    .c1_i (c1),
    .e0_i (e0),
    .e1_i (e1),
    .pal_o(pal)
  );

  assign pick = pal[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      texel_o     <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) texel_o <= pick;
    end
  end
endmodule

// File: rtl/tex_dec_checker.sv
module tex_dec_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [63:0] block_i,
  input logic [3:0]  texel_idx_i,
  input logic        out_valid_o,
  input logic [31:0] texel_o
);
  logic [1:0] sel_c;
  assign sel_c = 2'(block_i[63:32] >> {texel_idx_i, 1'b0});

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && texel_o == 32'h0));

  p_valid_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_valid_dn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_endpoint_opaque_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_c != 2'd3) |=> texel_o[7:0] == 8'hFF);

  p_alpha_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (texel_o[7:0] == 8'hFF || texel_o == 32'h0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(texel_o));
endmodule

bind texel_block_decoder tex_dec_checker u_chk (.*);

// File: tb/sim_texel_block_decoder.sv
`timescale 1ns/1ps
module sim_texel_block_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] block = '0;
  logic [3:0]  tidx = '0;
  logic        out_valid;
  logic [31:0] texel;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  texel_block_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .block_i(block), .texel_idx_i(tidx),
    .out_valid_o(out_valid), .texel_o(texel)
  );

  function automatic int widen5(int v);
    return (v << 3) | (v >> 2);
  endfunction
  function automatic int widen6(int v);
    return (v << 2) | (v >> 4);
  endfunction

  function automatic logic [31:0] ref_texel(logic [63:0] b, logic [3:0] n);
    int c0, c1, s;
    int a0[3], a1[3], o[3];
    c0 = int'(b[15:0]);
    c1 = int'(b[31:16]);
    s  = int'((b >> (32 + 2 * int'(n))) & 64'd3);
    a0[0] = widen5((c0 >> 11) & 31); a0[1] = widen6((c0 >> 5) & 63); a0[2] = widen5(c0 & 31);
    a1[0] = widen5((c1 >> 11) & 31); a1[1] = widen6((c1 >> 5) & 63); a1[2] = widen5(c1 & 31);
    if (s == 3 && c0 <= c1) return 32'h0;
    for (int k = 0; k < 3; k++) begin
      case (s)
        0: o[k] = a0[k];
        1: o[k] = a1[k];
        2: o[k] = (c0 > c1) ? (2 * a0[k] + a1[k]) / 3 : (a0[k] + a1[k]) / 2;
        default: o[k] = (a0[k] + 2 * a1[k]) / 3;
      endcase
    end
    return {o[0][7:0], o[1][7:0], o[2][7:0], 8'hFF};
  endfunction

  function automatic string tag_of(logic [63:0] b, logic [3:0] n);
    int s;
    s = int'((b >> (32 + 2 * int'(n))) & 64'd3);
    if (s < 2) return "R5";
    if (b[15:0] > b[31:16]) return "R6";
    if (s == 2) return "R7";
    return "R8";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model, advanced on every clock
  logic        m_valid = 1'b0;
  logic [31:0] m_texel = '0;
  string       m_tag = "R2";
  bit          m_armed = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_armed <= 1;
      m_valid <= in_valid;
      if (in_valid) begin
        m_texel <= ref_texel(block, tidx);
        m_tag   <= tag_of(block, tidx);
      end else begin
        m_tag   <= "R10";
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_armed && !done) begin
      check("R2", {31'd0, out_valid}, {31'd0, m_valid});
      check(m_tag, texel, m_texel);
    end
  end

  task automatic drive(logic [63:0] b, logic [3:0] n);
    @(negedge clk);
    in_valid = 1'b1; block = b; tidx = n;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [63:0] b;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", texel, 32'h0);
    rst_n = 1'b1;

    // R9 packing: red E0, blue E1, texel 0 selector 2
    drive({32'h0000_0002, 16'h001F, 16'hF800}, 4'd0);
    @(posedge clk); #1;
    check("R9", texel, 32'hAA00_55FF);
    // R3: texel 15 uses the top selector, texel 14 selector 0
    drive({32'hC000_0000, 16'h001F, 16'hF800}, 4'd15);
    @(posedge clk); #1;
    check("R3", texel, 32'h5500_AAFF);
    drive({32'hC000_0000, 16'h001F, 16'hF800}, 4'd14);
    @(posedge clk); #1;
    check("R3", texel, 32'hFF00_00FF);
    // R4 replication
    drive({32'h0, 16'h0000, 16'h8410}, 4'd5);
    @(posedge clk); #1;
    check("R4", texel, 32'h8482_84FF);
    // R8 / R7 equal endpoints
    drive({32'h0000_00C0, 16'h1234, 16'h1234}, 4'd3);
    @(posedge clk); #1;
    check("R8", texel, 32'h0);
    // R10 hold over idle cycles
    idle();
    @(posedge clk); #1;
    check("R10", texel, 32'h0);
    drive({32'h0000_0001, 16'hFFFF, 16'h0000}, 4'd0);
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R10", texel, 32'hFFFF_FFFF);
    // R7 midpoint with white/black swapped
    drive({32'h0000_0002, 16'hFFFF, 16'h0000}, 4'd0);
    @(posedge clk); #1;
    check("R7", texel, 32'h7F7F_7FFF);

    // random back-to-back sweep, mixed modes
    for (int i = 0; i < 3000; i++) begin
      b = {$urandom, $urandom};
      if (i % 7 == 0) b[31:16] = b[15:0];
      if (i % 5 == 0) b[31:0] = {b[15:0], b[31:16]};
      if (i % 9 == 0) idle();
      drive(b, 4'($urandom_range(0, 15)));
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule